// File: doc/BRIEF.md
# PCI Rotating-Priority Bus Arbiter

This block decides which of four PCI bus masters may drive the bus next. Master 0 is the on-chip bridge and masters 1 to 3 are off-chip devices. Every request and grant line is active-low. Priority rotates around the master that most recently began a transaction. While the bus is occupied, the winner is chosen again on every clock. Once the bus goes quiet the grant is frozen, so the holder can start its cycle. When nobody requests, the grant parks on the last master that used the bus.

A strap input is captured while reset is asserted and chooses the arbitration source. When the strap is high, this arbiter drives all four grants. When it is low, the block steps aside: its own grants stay deasserted, and the bridge's request and grant are passed to and from an off-chip arbiter through two pins.

Top module: `pci_rr_arbiter`

## Requirements
- R1: While reset is asserted with the strap high, the outputs settle so that only the bridge grant (`bridge_gnt_n_o`) is low, all `ext_gnt_n_o` bits are high and `pin_req_n_o` is high. The last-granted index resets to 3, which makes the bridge the highest-priority master after reset.
- R2: On a clock edge where the bus is busy (`frame_n_i` or `irdy_n_i` low), the grant moves to the first requester in the order L+1, L+2, L+3, L (mod 4), where L is the last-granted index. With no requester, the grant parks on L. Master index 0 is the bridge; index k (1..3) uses `ext_req_n_i[k-1]` and `ext_gnt_n_o[k-1]`.
- R3: On a clock edge where the bus is idle (`frame_n_i` and `irdy_n_i` both high), the grant does not change, whatever the requests are.
- R4: On a clock edge where `frame_n_i` is low after being high in the previous sampled cycle, L takes the index of the current grant holder. That same edge already rotates from the new L.
- R5: At most one grant output is low in any cycle. In internal mode exactly one is low.
- R6: A grant can pass straight from one master to another in a single clock, with no cycle in which no grant is asserted.
- R7: The strap is captured only while reset is asserted. Changes on the strap after reset have no effect on the mode.
- R8: In external mode, all `ext_gnt_n_o` bits are high, `bridge_gnt_n_o` follows `pin_gnt_n_i`, and `pin_req_n_o` follows `bridge_req_n_i` with no register in the path. In internal mode, `pin_req_n_o` stays high.
- R9: Internal grants are registered. A change on the request or bus-control inputs shows on the grants only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; the strap is captured while it is asserted |
| arb_strap_i | input | 1 | 1 selects this arbiter, 0 selects an off-chip arbiter |
| frame_n_i | input | 1 | Bus FRAME#, active-low |
| irdy_n_i | input | 1 | Bus IRDY#, active-low |
| bridge_req_n_i | input | 1 | Request from the bridge (master 0), active-low |
| bridge_gnt_n_o | output | 1 | Grant to the bridge, active-low |
| ext_req_n_i | input | 3 | Requests from masters 1..3 (bit k-1 = master k), active-low |
| ext_gnt_n_o | output | 3 | Grants to masters 1..3 (bit k-1 = master k), active-low |
| pin_req_n_o | output | 1 | Bridge request sent to the off-chip arbiter, active-low |
| pin_gnt_n_i | input | 1 | Grant from the off-chip arbiter for the bridge, active-low |

## Verification
The bound checker watches these properties on every cycle:
- grant exclusivity, and in internal mode that exactly one grant is held;
- that grants stay frozen across idle-bus edges;
- that a busy-bus grant always lands on a requester, or on the parked master when nobody requests;
- the external-mode pass-through, and that the captured mode never changes outside reset.

The exact rotation order can only be shown by the bench's scripted sequences, because it depends on the history of transaction starts. The same holds for the moment L moves at a FRAME# falling edge, the one-cycle grant latency, and the claim that strap changes after reset are ignored.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

    localparam int NUM_MASTERS = 4;
    localparam int NUM_EXT     = NUM_MASTERS - 1;
    localparam int IDX_W       = $clog2(NUM_MASTERS);

    typedef logic [IDX_W-1:0]       mst_idx_t;
    typedef logic [NUM_MASTERS-1:0] mst_vec_t;

    localparam mst_idx_t BRIDGE_IDX = '0;
    localparam mst_idx_t RESET_LAST = mst_idx_t'(NUM_MASTERS - 1);

    typedef enum logic {
        ARB_EXTERNAL = 1'b0,
        ARB_INTERNAL = 1'b1
    } arb_src_e;

    typedef struct packed {
        logic frame_n;
        logic irdy_n;
    } bus_ctl_t;

    typedef struct packed {
        logic idle;
        logic start;
    } bus_state_t;

    function automatic mst_idx_t rot_next(input mst_idx_t base, input int unsigned step);
        return mst_idx_t'((32'(base) + step) % 32'(NUM_MASTERS));
    endfunction

    function automatic mst_vec_t idx_to_onehot(input mst_idx_t idx);
        mst_vec_t oh;
        oh      = '0;
        oh[idx] = 1'b1;
        return oh;
    endfunction

endpackage

// File: rtl/pci_arb_busmon.sv
module pci_arb_busmon
    import pci_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ctl_t   bus_ctl_i,
    output bus_state_t bus_st_o
);

    logic frame_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_prev_q <= 1'b1;
        end else begin
            frame_prev_q <= bus_ctl_i.frame_n;
        end
    end

    always_comb begin
        bus_st_o.idle  = bus_ctl_i.frame_n & bus_ctl_i.irdy_n;
        bus_st_o.start = frame_prev_q & ~bus_ctl_i.frame_n;
    end

endmodule

// File: rtl/pci_arb_rotate.sv
module pci_arb_rotate
    import pci_arb_pkg::*;
(
    input  mst_vec_t req_i,
    input  mst_idx_t last_i,
    output mst_idx_t win_o
);

    mst_idx_t cand [NUM_MASTERS];

    for (genvar k = 0; k < NUM_MASTERS; k++) begin : g_cand
        assign cand[k] = rot_next(last_i, k + 1);
    end

    always_comb begin
        win_o = last_i;
        for (int k = NUM_MASTERS - 1; k >= 0; k--) begin
            if (req_i[cand[k]]) begin
                win_o = cand[k];
            end
        end
    end

endmodule

// File: rtl/pci_arb_strap.sv
module pci_arb_strap
    import pci_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               strap_i,
    input  mst_vec_t           grant_oh_i,
    input  logic               bridge_req_n_i,
    input  logic               pin_gnt_n_i,
    output arb_src_e           src_o,
    output logic               bridge_gnt_n_o,
    output logic [NUM_EXT-1:0] ext_gnt_n_o,
    output logic               pin_req_n_o
);

    arb_src_e src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= arb_src_e'(strap_i);
        end
    end

    assign src_o          = src_q;
    assign bridge_gnt_n_o = (src_q == ARB_INTERNAL) ? ~grant_oh_i[BRIDGE_IDX] : pin_gnt_n_i;
    assign pin_req_n_o    = (src_q == ARB_INTERNAL) ? 1'b1 : bridge_req_n_i;

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext_gnt
        assign ext_gnt_n_o[e] = (src_q == ARB_INTERNAL) ? ~grant_oh_i[e+1] : 1'b1;
    end

endmodule

// File: rtl/pci_rr_arbiter.sv
module pci_rr_arbiter
    import pci_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               arb_strap_i,
    input  logic               frame_n_i,
    input  logic               irdy_n_i,
    input  logic               bridge_req_n_i,
    output logic               bridge_gnt_n_o,
    input  logic [NUM_EXT-1:0] ext_req_n_i,
    output logic [NUM_EXT-1:0] ext_gnt_n_o,
    output logic               pin_req_n_o,
    input  logic               pin_gnt_n_i
);

    bus_ctl_t   bus_ctl;
    bus_state_t bus_st;
    mst_vec_t   req_act;
    mst_idx_t   gnt_q;
    mst_idx_t   last_q;
    mst_idx_t   last_eff;
    mst_idx_t   win;
    arb_src_e   src_w;
    logic       int_mode_w;

    assign bus_ctl = '{frame_n: frame_n_i, irdy_n: irdy_n_i};
    assign req_act = {~ext_req_n_i, ~bridge_req_n_i};

    pci_arb_busmon u_busmon (
        .clk       (clk),
        .rst       (rst),
        .bus_ctl_i (bus_ctl),
        .bus_st_o  (bus_st)
    );

    // A transaction starting on this edge moves the rotation point to its owner
    assign last_eff = bus_st.start ? gnt_q : last_q;

    pci_arb_rotate u_rotate (
        .req_i  (req_act),
        .last_i (last_eff),
        .win_o  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q  <= BRIDGE_IDX;
            last_q <= RESET_LAST;
        end else begin
            if (bus_st.start) begin
                last_q <= gnt_q;
            end
            if (!bus_st.idle) begin
                gnt_q <= win;
            end
        end
    end

    pci_arb_strap u_strap (
        .clk            (clk),
        .rst            (rst),
        .strap_i        (arb_strap_i),
        .grant_oh_i     (idx_to_onehot(gnt_q)),
        .bridge_req_n_i (bridge_req_n_i),
        .pin_gnt_n_i    (pin_gnt_n_i),
        .src_o          (src_w),
        .bridge_gnt_n_o (bridge_gnt_n_o),
        .ext_gnt_n_o    (ext_gnt_n_o),
        .pin_req_n_o    (pin_req_n_o)
    );

    assign int_mode_w = (src_w == ARB_INTERNAL);

endmodule

// File: rtl/pci_rr_arbiter_chk.sv
module pci_rr_arbiter_chk
    import pci_arb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               frame_n,
    input logic               irdy_n,
    input logic               bridge_req_n,
    input logic [NUM_EXT-1:0] ext_req_n,
    input logic               bridge_gnt_n,
    input logic [NUM_EXT-1:0] ext_gnt_n,
    input logic               pin_req_n,
    input logic               pin_gnt_n,
    input logic               int_mode,
    input mst_idx_t           last_idx
);

    mst_vec_t gnt_hi;
    mst_vec_t req_hi;
    logic     busy;

    assign gnt_hi = ~{ext_gnt_n, bridge_gnt_n};
    assign req_hi = ~{ext_req_n, bridge_req_n};
    assign busy   = ~(frame_n & irdy_n);

    // R5
    one_low_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_hi));

    // R5
    int_one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        int_mode |-> ($countones(gnt_hi) == 1));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int_mode && !busy) |=> $stable(gnt_hi));

    // R2
    busy_to_req_chk: assert property (@(posedge clk) disable iff (rst)
        (int_mode && busy && (req_hi != '0)) |=> ((gnt_hi & $past(req_hi)) != '0));

    // R2
    park_last_chk: assert property (@(posedge clk) disable iff (rst)
        (int_mode && busy && (req_hi == '0)) |=> (gnt_hi == idx_to_onehot(last_idx)));

    // R8
    ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !int_mode |-> ((ext_gnt_n == '1) && (bridge_gnt_n == pin_gnt_n) && (pin_req_n == bridge_req_n)));

    // R8
    int_pin_idle_chk: assert property (@(posedge clk) disable iff (rst)
        int_mode |-> pin_req_n);

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(int_mode));

endmodule

bind pci_rr_arbiter pci_rr_arbiter_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .frame_n      (frame_n_i),
    .irdy_n       (irdy_n_i),
    .bridge_req_n (bridge_req_n_i),
    .ext_req_n    (ext_req_n_i),
    .bridge_gnt_n (bridge_gnt_n_o),
    .ext_gnt_n    (ext_gnt_n_o),
    .pin_req_n    (pin_req_n_o),
    .pin_gnt_n    (pin_gnt_n_i),
    .int_mode     (int_mode_w),
    .last_idx     (last_q)
);

// File: tb/pci_rr_arbiter_tb_top.sv
`timescale 1ns/1ps
module pci_rr_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       strap;
    logic       frame_n;
    logic       irdy_n;
    logic       bridge_req_n;
    logic       bridge_gnt_n;
    logic [2:0] ext_req_n;
    logic [2:0] ext_gnt_n;
    logic       pin_req_n;
    logic       pin_gnt_n;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;

    pci_rr_arbiter dut_i (
        .clk            (clk),
        .rst            (rst),
        .arb_strap_i    (strap),
        .frame_n_i      (frame_n),
        .irdy_n_i       (irdy_n),
        .bridge_req_n_i (bridge_req_n),
        .bridge_gnt_n_o (bridge_gnt_n),
        .ext_req_n_i    (ext_req_n),
        .ext_gnt_n_o    (ext_gnt_n),
        .pin_req_n_o    (pin_req_n),
        .pin_gnt_n_i    (pin_gnt_n)
    );

    // Fields: {tag[1:0], frame_n, irdy_n, req[3:0] active-high, expected grant one-hot[3:0]}
    // bit 0 = bridge, bit k = external master k; tag 0=R2 1=R3 2=R4 3=R6
    localparam int NV = 15;
    localparam logic [11:0] VEC [NV] = '{
        12'b01_1_1_0110_0001,
        12'b00_1_0_0110_0010,
        12'b11_1_0_0100_0100,
        12'b10_0_0_1100_1000,
        12'b00_0_0_0000_0100,
        12'b01_1_1_0011_0100,
        12'b00_1_0_0011_0001,
        12'b10_0_0_1111_0010,
        12'b00_0_0_1101_0100,
        12'b00_0_1_0001_0001,
        12'b01_1_1_1000_0001,
        12'b10_0_0_1000_1000,
        12'b01_1_1_0000_1000,
        12'b10_0_0_0000_1000,
        12'b10_1_0_1111_0001
    };

    function automatic logic [3:0] gnt_hi();
        return ~{ext_gnt_n, bridge_gnt_n};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive_req(input logic [3:0] req);
        bridge_req_n = ~req[0];
        ext_req_n    = ~req[3:1];
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst = 1'b1; strap = s;
        frame_n = 1'b1; irdy_n = 1'b1; pin_gnt_n = 1'b1;
        drive_req(4'b0000);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; strap = 1'b1; frame_n = 1'b1; irdy_n = 1'b1;
        pin_gnt_n = 1'b1; bridge_req_n = 1'b1; ext_req_n = 3'b111;

        // R1: reset state, internal mode
        do_reset(1'b1);
        chk("R1 grant", {4'b0, gnt_hi()}, 8'b0000_0001);
        chk("R1 pin_req", {7'b0, pin_req_n}, 8'd1);

        // Vector walk through rotation, parking, idle hold and start edges
        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            string tag;
            v = VEC[i];
            case (v[11:10])
                2'd0: tag = "R2";
                2'd1: tag = "R3";
                2'd2: tag = "R4";
                default: tag = "R6";
            endcase
            @(negedge clk);
            frame_n = v[9]; irdy_n = v[8];
            drive_req(v[7:4]);
            @(posedge clk); #1;
            chk(tag, {4'b0, gnt_hi()}, {4'b0, v[3:0]});
            // R5: exactly one grant held in internal mode
            chk("R5 count", 8'($countones(gnt_hi())), 8'd1);
        end

        // R9: grant changes only after the next rising edge
        do_reset(1'b1);
        @(negedge clk);
        irdy_n = 1'b0; drive_req(4'b0010);
        #1;
        chk("R9 before edge", {4'b0, gnt_hi()}, 8'b0000_0001);
        @(posedge clk); #1;
        chk("R9 after edge", {4'b0, gnt_hi()}, 8'b0000_0010);

        // R7: strap change after reset is ignored (stays internal)
        do_reset(1'b1);
        strap = 1'b0; pin_gnt_n = 1'b1; bridge_req_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 bridge_gnt", {7'b0, bridge_gnt_n}, 8'd0);
        chk("R7 pin_req", {7'b0, pin_req_n}, 8'd1);

        // R8: external mode pass-through
        do_reset(1'b0);
        chk("R8 ext_gnt", {5'b0, ext_gnt_n}, 8'b0000_0111);
        chk("R8 bridge_gnt hi", {7'b0, bridge_gnt_n}, 8'd1);
        pin_gnt_n = 1'b0; #1;
        chk("R8 bridge_gnt lo", {7'b0, bridge_gnt_n}, 8'd0);
        bridge_req_n = 1'b0; #1;
        chk("R8 pin_req lo", {7'b0, pin_req_n}, 8'd0);
        @(negedge clk);
        irdy_n = 1'b0; frame_n = 1'b0; ext_req_n = 3'b000;
        @(posedge clk); #1;
        chk("R8 ext_gnt busy", {5'b0, ext_gnt_n}, 8'b0000_0111);
        // R7: raising the strap after reset keeps external mode
        @(negedge clk);
        strap = 1'b1; pin_gnt_n = 1'b1;
        @(posedge clk); #1;
        chk("R7 still external", {7'b0, bridge_gnt_n}, 8'd1);
        chk("R7 ext_gnt", {5'b0, ext_gnt_n}, 8'b0000_0111);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule